// File: doc/BRIEF.md
# APB Wait-State Ready Generator

This block sits beside a register file on an APB subordinate and decides when each access finishes. Every transfer is stretched by a fixed number of wait states, set by a parameter. The setup phase starts a registered down-counter. PREADY is driven straight from a flop, so it cannot glitch and it is known as soon as reset is released.

The block also gives the register file one-cycle commit strobes, one for writes and one for reads. A strobe is high only in the single cycle where the transfer really completes, however long PENABLE stays high before that. Read data from the register file is captured into a registered PRDATA on the same clock edge that raises PREADY, so the data and the ready signal always appear in the same cycle.

If the manager drops the select before the transfer completes, the transfer is abandoned. No strobe fires, and the next transfer begins a fresh count.

Top module: `apb_wait_ready`

## Requirements
- R1: While the synchronous active-low reset `rst_n` is low at a clock edge, `pready` and `prdata` become 0 in the following cycle. This also holds when reset is applied in the middle of a wait sequence.
- R2: With `WAIT_CYCLES` = N > 0, a setup phase (`psel`=1, `penable`=0) is followed by exactly N access-phase cycles (`psel`=1, `penable`=1) with `pready`=0. `pready` is 1 in access cycle N+1.
- R3: With `WAIT_CYCLES` = 0, `pready` is 1 in the first access-phase cycle after the setup phase.
- R4: `pready` is high for exactly one cycle per transfer. It is 0 in the cycle after completion, even if `psel` and `penable` stay high.
- R5: `wr_commit` is 1 only in the completing cycle of a transfer with `pwrite`=1, and so fires exactly once per write. It is 0 in every wait cycle.
- R6: `rd_commit` is 1 only in the completing cycle of a transfer with `pwrite`=0, and so fires exactly once per read.
- R7: In the completing cycle of a read, `prdata` equals the `rd_data_in` value present in the cycle before it. In every other cycle, including the completing cycle of a write, `prdata` is 0.
- R8: A setup phase in the cycle right after a completing cycle starts a new transfer with the full N wait cycles.
- R9: If `psel` is 0 in any cycle before completion, `pready` is 0 in the next cycle, no commit strobe fires for that transfer, and the following transfer waits the full N cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| psel | input | 1 | Subordinate select from the manager |
| penable | input | 1 | Access-phase flag from the manager |
| pwrite | input | 1 | 1 = write transfer, 0 = read transfer |
| rd_data_in | input | DATA_W | Read value of the addressed register, from the register file |
| pready | output | 1 | Registered transfer-complete flag |
| prdata | output | DATA_W | Registered read data, valid in the completing cycle |
| wr_commit | output | 1 | One-cycle write strobe to the register file |
| rd_commit | output | 1 | One-cycle read strobe to the register file |

## Verification
Each result is due at a fixed cycle. `pready` and `prdata` are flop outputs, so they change one clock edge after the cycle that decides them: the last wait cycle, or the setup cycle when N is 0. The commit strobes are combinational from the registered `pready` and the current inputs, so they show up in the completing cycle itself.

The bench drives every input on the falling edge and samples one nanosecond later, inside the same cycle. The expected value for access cycle k is therefore worked out from k alone. Two instances, with N=3 and N=0, share the same stimulus. Because of this, each of the longer transfers also exercises the zero-wait instance with PENABLE held high after it has completed.

// File: rtl/apb_wait_pkg.sv
// Package: shared types for the APB wait-state ready generator.
// Assumes: nothing; pure type definitions.
package apb_wait_pkg;

    // Transfer phase as tracked by the ready controller.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,   // no transfer in progress
        PH_WAIT = 2'd1,   // access phase, counting wait states
        PH_DONE = 2'd2    // pready is high, completing cycle
    } xfer_phase_e;

endpackage

// File: rtl/apb_wait_counter.sv
// Module: down-counter of remaining wait states.
// Does: loads the wait count on request, decrements while running, and flags
//       the cycle in which one wait state remains.
// Assumes: load and run are never both high; LOAD_VAL fits in CNT_W bits.
module apb_wait_counter #(
    parameter int CNT_W    = 2,
    parameter int LOAD_VAL = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic last
);

    logic [CNT_W-1:0] remain_q;

    // Count register: load on transfer start, step down while waiting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else if (load) begin
            remain_q <= CNT_W'(LOAD_VAL);
        end else if (run && (remain_q != '0)) begin
            remain_q <= remain_q - CNT_W'(1);
        end
    end

    // Final-wait flag: one wait cycle left, so ready rises at the next edge.
    always_comb begin
        last = (remain_q == CNT_W'(1));
    end

endmodule

// File: rtl/apb_ready_ctrl.sv
// Module: phase tracker and registered PREADY source.
// Does: detects the setup phase, sequences the wait states, and drives pready
//       from a flop that resets to 0. It also produces the "arm" event that
//       tells the data path to capture read data on the edge that raises pready.
// Assumes: the counter's "last" flag is meaningful only in PH_WAIT.
module apb_ready_ctrl
    import apb_wait_pkg::*;
#(
    parameter int WAIT_CYCLES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic psel,
    input  logic penable,
    input  logic cnt_last,
    output logic cnt_load,
    output logic cnt_run,
    output logic arm,
    output logic pready
);

    localparam bit ZERO_WAIT = (WAIT_CYCLES == 0);

    xfer_phase_e phase_q, phase_d;
    logic        ready_d;

    // Next-state decode: abort, setup-phase start, wait counting, completion.
    always_comb begin
        phase_d  = phase_q;
        ready_d  = 1'b0;
        cnt_load = 1'b0;
        cnt_run  = 1'b0;
        arm      = 1'b0;
        if (!psel) begin
            phase_d = PH_IDLE;
        end else if (!penable) begin
            if (ZERO_WAIT) begin
                phase_d = PH_DONE;
                ready_d = 1'b1;
                arm     = 1'b1;
            end else begin
                phase_d  = PH_WAIT;
                cnt_load = 1'b1;
            end
        end else begin
            unique case (phase_q)
                PH_WAIT: begin
                    cnt_run = 1'b1;
                    if (cnt_last) begin
                        phase_d = PH_DONE;
                        ready_d = 1'b1;
                        arm     = 1'b1;
                    end
                end
                PH_DONE: phase_d = PH_IDLE;
                default: phase_d = PH_IDLE;
            endcase
        end
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
        end else begin
            phase_q <= phase_d;
        end
    end

    // PREADY flop: known-low out of reset, no combinational path to the port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pready <= 1'b0;
        end else begin
            pready <= ready_d;
        end
    end

endmodule

// File: rtl/apb_rdata_reg.sv
// Module: registered read-data stage.
// Does: captures the addressed register's value on the edge that raises
//       pready for a read, and returns zero in every other cycle.
// Assumes: rd_data_in is valid in the last wait cycle (or in the setup cycle
//          when there are no wait states) and pwrite is stable per transfer.
module apb_rdata_reg #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic              pwrite,
    input  logic [DATA_W-1:0] rd_data_in,
    output logic [DATA_W-1:0] prdata
);

    // Read-data capture, phase-aligned with the pready flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prdata <= '0;
        end else if (arm && !pwrite) begin
            prdata <= rd_data_in;
        end else begin
            prdata <= '0;
        end
    end

endmodule

// File: rtl/apb_commit_gen.sv
// Module: commit strobe generator.
// Does: qualifies the write and read strobes on the full completion condition.
// Assumes: pready is the registered output of apb_ready_ctrl.
module apb_commit_gen (
    input  logic psel,
    input  logic penable,
    input  logic pwrite,
    input  logic pready,
    output logic wr_commit,
    output logic rd_commit
);

    logic complete;

    // Completion qualifier and direction split.
    always_comb begin
        complete  = psel && penable && pready;
        wr_commit = complete && pwrite;
        rd_commit = complete && !pwrite;
    end

endmodule

// File: rtl/apb_wait_ready.sv
// Module: top level of the APB wait-state ready generator.
// Does: inserts WAIT_CYCLES wait states into every APB access, drives a
//       registered PREADY and PRDATA, and issues single-cycle commit strobes.
// Assumes: a standard APB manager (a setup phase precedes each access phase,
//          pwrite is stable through a transfer); synchronous active-low reset.
module apb_wait_ready #(
    parameter int WAIT_CYCLES = 3,
    parameter int DATA_W      = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [DATA_W-1:0] rd_data_in,
    output logic              pready,
    output logic [DATA_W-1:0] prdata,
    output logic              wr_commit,
    output logic              rd_commit
);

    localparam int CNT_W = (WAIT_CYCLES > 0) ? $clog2(WAIT_CYCLES + 1) : 1;

    logic cnt_load;
    logic cnt_run;
    logic cnt_last;
    logic arm;

    // The wait counter exists only when there are wait states to count.
    generate
        if (WAIT_CYCLES > 0) begin : g_counter
            apb_wait_counter #(
                .CNT_W    (CNT_W),
                .LOAD_VAL (WAIT_CYCLES)
            ) u_counter (
                .clk   (clk),
                .rst_n (rst_n),
                .load  (cnt_load),
                .run   (cnt_run),
                .last  (cnt_last)
            );
        end else begin : g_no_counter
            assign cnt_last = 1'b0;
        end
    endgenerate

    apb_ready_ctrl #(
        .WAIT_CYCLES (WAIT_CYCLES)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .psel     (psel),
        .penable  (penable),
        .cnt_last (cnt_last),
        .cnt_load (cnt_load),
        .cnt_run  (cnt_run),
        .arm      (arm),
        .pready   (pready)
    );

    apb_rdata_reg #(
        .DATA_W (DATA_W)
    ) u_rdata (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm        (arm),
        .pwrite     (pwrite),
        .rd_data_in (rd_data_in),
        .prdata     (prdata)
    );

    apb_commit_gen u_commit (
        .psel      (psel),
        .penable   (penable),
        .pwrite    (pwrite),
        .pready    (pready),
        .wr_commit (wr_commit),
        .rd_commit (rd_commit)
    );

endmodule

// File: rtl/apb_wait_ready_chk.sv
// Module: protocol checker for apb_wait_ready, attached by bind.
// Does: checks the timing of pready, the strobes and prdata against the inputs.
// Assumes: same parameters as the bound instance.
module apb_wait_ready_chk #(
    parameter int WAIT_CYCLES = 3,
    parameter int DATA_W      = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              psel,
    input logic              penable,
    input logic              pwrite,
    input logic              pready,
    input logic [DATA_W-1:0] prdata,
    input logic              wr_commit,
    input logic              rd_commit
);

    logic [15:0] waits_seen;

    // Count access cycles without ready since the most recent setup phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            waits_seen <= '0;
        end else if (psel && !penable) begin
            waits_seen <= '0;
        end else if (psel && penable && !pready && (waits_seen != 16'hFFFF)) begin
            waits_seen <= waits_seen + 16'd1;
        end
    end

    // R2: completion arrives after exactly WAIT_CYCLES wait cycles.
    assert_wait_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && penable && pready) |-> (waits_seen == 16'(WAIT_CYCLES)));

    // R2 / R3: the cycle after a setup phase carries ready only with zero waits.
    generate
        if (WAIT_CYCLES == 0) begin : g_zero
            assert_zero_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (psel && !penable) |=> pready);
        end else begin : g_wait
            assert_first_wait_R2: assert property (@(posedge clk) disable iff (!rst_n)
                (psel && !penable) |=> !pready);
        end
    endgenerate

    // R4: ready drops after the completing cycle.
    assert_single_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && penable && pready) |=> !pready);

    // R5: the write strobe never lasts two cycles.
    assert_wr_once_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |=> !wr_commit);

    // R6: the read strobe never lasts two cycles.
    assert_rd_once_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_commit |=> !rd_commit);

    // R7: read data is quiet outside a completing read.
    assert_prdata_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!pready || pwrite) |-> (prdata == '0));

    // R9: a cycle without select leaves ready low in the next cycle.
    assert_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !psel |=> !pready);

endmodule

bind apb_wait_ready apb_wait_ready_chk #(
    .WAIT_CYCLES (WAIT_CYCLES),
    .DATA_W      (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .psel      (psel),
    .penable   (penable),
    .pwrite    (pwrite),
    .pready    (pready),
    .prdata    (prdata),
    .wr_commit (wr_commit),
    .rd_commit (rd_commit)
);

// File: tb/apb_wait_ready_test.sv
`timescale 1ns/1ps
module apb_wait_ready_test;

    localparam int N  = 3;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          psel = 1'b0;
    logic          penable = 1'b0;
    logic          pwrite = 1'b0;
    logic [DW-1:0] rd_data = '0;

    logic          pready, wr_commit, rd_commit;
    logic [DW-1:0] prdata;
    logic          z_pready, z_wr, z_rd;
    logic [DW-1:0] z_prdata;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    apb_wait_ready #(.WAIT_CYCLES(N), .DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .rd_data_in(rd_data), .pready(pready),
        .prdata(prdata), .wr_commit(wr_commit), .rd_commit(rd_commit));

    apb_wait_ready #(.WAIT_CYCLES(0), .DATA_W(DW)) uut_zero (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .rd_data_in(rd_data), .pready(z_pready),
        .prdata(z_prdata), .wr_commit(z_wr), .rd_commit(z_rd));

    // Vector: [36] write, [35:32] idle gap before setup, [31:0] read value.
    localparam logic [36:0] VEC [8] = '{
        {1'b1, 4'd1, 32'h0000_0000},
        {1'b0, 4'd0, 32'hA5A5_0001},
        {1'b0, 4'd0, 32'h1234_5678},
        {1'b1, 4'd0, 32'hDEAD_BEEF},
        {1'b0, 4'd2, 32'hFFFF_FFFF},
        {1'b1, 4'd1, 32'h0F0F_0F0F},
        {1'b1, 4'd0, 32'h8000_0001},
        {1'b0, 4'd3, 32'h0000_0001}
    };

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic idle_cycle();
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; #1;
        check("R9", {31'd0, pready}, 32'd0);
        check("R4", {31'd0, z_pready}, 32'd0);
        check("R9", {30'd0, wr_commit, rd_commit}, 32'd0);
    endtask

    task automatic setup_cycle(input logic wr, input logic [DW-1:0] d);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = wr; rd_data = d; #1;
        check("R2", {31'd0, pready}, 32'd0);
        check("R7", prdata, '0);
    endtask

    // Full transfer with N access cycles held; both instances are checked.
    task automatic xfer(input logic wr, input logic [DW-1:0] d, input int gap);
        for (int g = 0; g < gap; g++) idle_cycle();
        setup_cycle(wr, d);
        for (int k = 0; k <= N; k++) begin
            @(negedge clk);
            penable = 1'b1; #1;
            check("R2", {31'd0, pready}, {31'd0, k == N});
            check("R5", {31'd0, wr_commit}, {31'd0, wr && (k == N)});
            check("R6", {31'd0, rd_commit}, {31'd0, !wr && (k == N)});
            check("R7", prdata, (!wr && (k == N)) ? d : '0);
            if (k == 0) begin
                check("R3", {31'd0, z_pready}, 32'd1);
                check("R7", z_prdata, wr ? '0 : d);
            end else begin
                check("R4", {31'd0, z_pready}, 32'd0);
                check("R5", {31'd0, z_wr}, 32'd0);
                check("R6", {31'd0, z_rd}, 32'd0);
            end
        end
    endtask

    // Transfer abandoned after 'acc' access cycles.
    task automatic abort_xfer(input logic wr, input int acc);
        setup_cycle(wr, 32'hCAFE_0000);
        for (int k = 0; k < acc; k++) begin
            @(negedge clk);
            penable = 1'b1; #1;
            check("R9", {31'd0, pready}, 32'd0);
            check("R9", {30'd0, wr_commit, rd_commit}, 32'd0);
        end
        for (int i = 0; i < N + 1; i++) idle_cycle();
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1: reset state.
        repeat (2) @(negedge clk);
        #1;
        check("R1", {31'd0, pready}, 32'd0);
        check("R1", prdata, '0);
        check("R1", {30'd0, wr_commit, rd_commit}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // Vector table: reads, writes, gaps; gap 0 gives back-to-back (R8).
        foreach (VEC[i]) begin
            xfer(VEC[i][36], VEC[i][31:0], int'(VEC[i][35:32]));
        end

        // R8: setup right after completion, read then write.
        xfer(1'b0, 32'h5555_AAAA, 0);
        xfer(1'b1, 32'h0, 0);
        idle_cycle();

        // R9: abort after one and after N-1 access cycles, then full transfer.
        abort_xfer(1'b1, 1);
        xfer(1'b1, 32'h0, 0);
        idle_cycle();
        abort_xfer(1'b0, N - 1);
        xfer(1'b0, 32'h7777_0007, 0);

        // R1: reset in the last wait cycle keeps pready low afterwards.
        setup_cycle(1'b0, 32'h0BAD_0BAD);
        for (int k = 0; k < N; k++) begin
            @(negedge clk);
            penable = 1'b1;
            if (k == N - 1) rst_n = 1'b0;
        end
        @(negedge clk);
        rst_n = 1'b1; #1;
        check("R1", {31'd0, pready}, 32'd0);
        check("R1", prdata, '0);
        check("R1", {30'd0, rd_commit, wr_commit}, 32'd0);
        idle_cycle();
        xfer(1'b0, 32'h2468_ACE0, 0);
        idle_cycle();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule